// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM with 9-bit byte lanes. Each lane holds 8 data bits and 1 parity bit. Address, control and write data are captured on the rising clock edge. Read data is not registered: it comes from the array combinationally at the registered address, so a read is visible in the cycle right after the edge that captured it.

An access starts on one of two load strobes. One strobe is meant for a processor, the other for a cache controller. A load captures the full word address. The upper address bits then stay fixed, and the two low bits feed a beat counter. While the advance input is held low on later edges, the counter steps through a four-word group. A static pin sets the beat order: linear (add the beat count, modulo 4) or XOR (base XOR beat count). Writes update either every lane at once, or only the lanes picked by per-lane selects. Chip enable and two chip selects are sampled at the edge. Output enable and the doze input act at once, without a clock.

The lane count is a parameter, set to 4 or 2. With 2 lanes, the upper two lane selects are ignored. The depth is 2^ADDR_W words.

Top module: `fsb_sram`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, no access is active and `dq_drv` is 0. Whenever `dq_drv` is 0, `dq_out` is all zeros.
- R2: An edge with `cpu_ld_n`=0, `en_n`=0, `sel_a`=1 and `sel_b_n`=0 loads `addr` and starts a read. This holds whatever the write inputs are. In the next cycle `dq_drv`=1 and `dq_out` shows the word at `addr`.
- R3: An edge with `cache_ld_n`=0 that does not also start a processor load, with `en_n`=0 and both chip selects active, loads `addr`. If a write is requested, the word at `addr` is written from `dq_in` at that edge. Otherwise the word is read out in the next cycle.
- R4: With `order_xor`=0, each edge with no load and `adv_n`=0 moves to the next beat. Beat n (counted since the load) has low address bits (base + n) mod 4. The upper address bits stay the same.
- R5: With `order_xor`=1, beat n has low address bits base XOR n. The upper address bits stay the same.
- R6: An edge with no load and `adv_n`=1 keeps the current address, so the same word is read again. A write requested on any edge that continues a burst goes to the address of that edge's beat.
- R7: `wr_all_n`=0 writes all lanes, whatever `wr_byte_n` and `lane_n` are.
- R8: With `wr_all_n`=1 and `wr_byte_n`=0, only lane i with `lane_n[i]`=0 is written. Lane i is data bits [9i+8:9i]. With `wr_all_n`=1 and `wr_byte_n`=1, the cycle is a read.
- R9: With LANES=2, `lane_n[3:2]` are ignored. If a lane-write selects only those lanes, nothing is written and the cycle is a read.
- R10: While `en_n`=1, the processor strobe is ignored. With no cache strobe present, the edge only continues the current access.
- R11: When both strobes are active on the same edge, the processor strobe takes precedence. The cycle is a read, and the array is not changed.
- R12: A cache-strobe edge with `en_n`=1, or any load edge with a chip select inactive, ends the access. `dq_drv` is 0 in the next cycle, and later non-load edges neither read nor write.
- R13: `oe_n`=1 forces `dq_drv` to 0 at once, with no clock edge needed, and does not change the access state.
- R14: `doze`=1 forces `dq_drv` to 0 at once. Edges while it is high do not load, advance or write. The array and the current address are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low; clears the access state only |
| en_n | input | 1 | Chip enable, active low, sampled at the edge |
| sel_a | input | 1 | Chip select, active high, sampled at the edge |
| sel_b_n | input | 1 | Chip select, active low, sampled at the edge |
| cpu_ld_n | input | 1 | Processor load strobe, active low |
| cache_ld_n | input | 1 | Cache-controller load strobe, active low |
| adv_n | input | 1 | Beat advance, active low |
| order_xor | input | 1 | Static beat order: 0 linear, 1 XOR |
| addr | input | ADDR_W | Word address |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Lane-write enable, active low |
| lane_n | input | 4 | Per-lane write selects, active low, bit i is lane i |
| dq_in | input | 9*LANES | Write data |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| doze | input | 1 | Sleep, active high, asynchronous |
| dq_out | output | 9*LANES | Read data, zero when not driven |
| dq_drv | output | 1 | High when the outputs are driven; low means high impedance |

## Verification
The bench runs bursts in both beat orders from a base that is not 0, so it can see the wrap inside the four-word group. A counter that carried into the upper bits, or that used the other order, would return the wrong neighbour word. It also sets up strobe conflicts: both strobes with a write pending, and a processor strobe while the chip is disabled. A wrong priority would write the array or drop the current access, and a later read-back shows either. Deselect, doze and suspend cycles are each followed by a write attempt and then a read-back. A design that kept the access alive, stepped the counter while dozing, or ignored the beat address of a continued write leaves a word changed that should have stayed the same. Lane writes use select patterns that the narrow configuration must partly or fully ignore.

// File: rtl/fsb_pkg.sv
`timescale 1ns/1ps
package fsb_pkg;
   localparam int unsigned LANE_BITS = 9;
   localparam int unsigned MAX_LANES = 4;

   typedef enum logic [1:0] {
      B_HOLD = 2'd0,
      B_LOAD = 2'd1,
      B_STEP = 2'd2
   } burst_op_e;

   function automatic logic [1:0] beat_low(input logic [1:0] base,
                                           input logic [1:0] n,
                                           input logic       xor_order);
      return xor_order ? (base ^ n) : (base + n);
   endfunction
endpackage

// File: rtl/fsb_ctrl.sv
`timescale 1ns/1ps
module fsb_ctrl
   import fsb_pkg::*;
#(
   parameter int unsigned LANES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_n,
   input  logic                 sel_a,
   input  logic                 sel_b_n,
   input  logic                 cpu_ld_n,
   input  logic                 cache_ld_n,
   input  logic                 adv_n,
   input  logic                 wr_all_n,
   input  logic                 wr_byte_n,
   input  logic [MAX_LANES-1:0] lane_n,
   input  logic                 doze,
   output burst_op_e            bop,
   output logic [LANES-1:0]     lane_we,
   output logic                 rd_active
);
   logic             active_q, rd_q;
   logic             selected, p_go, c_go, start, load;
   logic             wr_any, cyc_ok, do_wr;
   logic [LANES-1:0] lane_sel, wr_lanes;

   always_comb begin
      lane_sel = ~lane_n[LANES-1:0];
      selected = sel_a & ~sel_b_n;
      p_go     = ~cpu_ld_n & ~en_n;
      c_go     = ~cache_ld_n & ~p_go;
      start    = p_go | c_go;
      load     = start & ~en_n & selected;
      wr_any   = ~wr_all_n | (~wr_byte_n & (|lane_sel));
      wr_lanes = ~wr_all_n ? {LANES{1'b1}} : (~wr_byte_n ? lane_sel : '0);
      cyc_ok   = rst_n & ~doze & (load | (~start & active_q));
      do_wr    = cyc_ok & ~p_go & wr_any;
      lane_we  = do_wr ? wr_lanes : '0;
      if (doze)
         bop = B_HOLD;
      else if (load)
         bop = B_LOAD;
      else if (~start & active_q & ~adv_n)
         bop = B_STEP;
      else
         bop = B_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rd_q     <= 1'b0;
      end else if (!doze) begin
         if (load)
            active_q <= 1'b1;
         else if (start)
            active_q <= 1'b0;
         if (cyc_ok)
            rd_q <= ~do_wr;
      end
   end

   assign rd_active = active_q & rd_q;
endmodule

// File: rtl/fsb_burst.sv
`timescale 1ns/1ps
module fsb_burst
   import fsb_pkg::*;
#(
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  burst_op_e         bop,
   input  logic              order_xor,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [ADDR_W-1:0] nxt_addr
);
   localparam int unsigned UP_W = ADDR_W - 2;

   logic [UP_W-1:0] up_q;
   logic [1:0]      lo_q, cnt_q;

   assign eff_addr = {up_q, beat_low(lo_q, cnt_q, order_xor)};

   always_comb begin
      unique case (bop)
         B_LOAD:  nxt_addr = addr_in;
         B_STEP:  nxt_addr = {up_q, beat_low(lo_q, cnt_q + 2'd1, order_xor)};
         default: nxt_addr = eff_addr;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         up_q  <= '0;
         lo_q  <= '0;
         cnt_q <= '0;
      end else if (bop == B_LOAD) begin
         up_q  <= addr_in[ADDR_W-1:2];
         lo_q  <= addr_in[1:0];
         cnt_q <= '0;
      end else if (bop == B_STEP) begin
         cnt_q <= cnt_q + 2'd1;
      end
   end
endmodule

// File: rtl/fsb_array.sv
`timescale 1ns/1ps
module fsb_array
   import fsb_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LANES  = 4
) (
   input  logic                       clk,
   input  logic [LANES-1:0]           lane_we,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [LANES*LANE_BITS-1:0] wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [LANES*LANE_BITS-1:0] rd_data
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_BITS-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[g])
            mem[wr_addr] <= wr_data[g*LANE_BITS +: LANE_BITS];
      end

      assign rd_data[g*LANE_BITS +: LANE_BITS] = mem[rd_addr];
   end
endmodule

// File: rtl/fsb_sram.sv
`timescale 1ns/1ps
module fsb_sram
   import fsb_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LANES  = 4,
   localparam int unsigned DW    = LANES * LANE_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_n,
   input  logic                 sel_a,
   input  logic                 sel_b_n,
   input  logic                 cpu_ld_n,
   input  logic                 cache_ld_n,
   input  logic                 adv_n,
   input  logic                 order_xor,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wr_all_n,
   input  logic                 wr_byte_n,
   input  logic [MAX_LANES-1:0] lane_n,
   input  logic [DW-1:0]        dq_in,
   input  logic                 oe_n,
   input  logic                 doze,
   output logic [DW-1:0]        dq_out,
   output logic                 dq_drv
);
   if (LANES != 2 && LANES != 4) begin : g_bad_lanes
      $error("fsb_sram: LANES must be 2 or 4");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("fsb_sram: ADDR_W must be at least 3");
   end

   burst_op_e         bop;
   logic [LANES-1:0]  lane_we;
   logic              rd_active;
   logic [ADDR_W-1:0] eff_addr, nxt_addr;
   logic [DW-1:0]     rd_data;

   fsb_ctrl #(.LANES(LANES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .en_n(en_n), .sel_a(sel_a), .sel_b_n(sel_b_n),
      .cpu_ld_n(cpu_ld_n), .cache_ld_n(cache_ld_n), .adv_n(adv_n),
      .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n), .doze(doze),
      .bop(bop), .lane_we(lane_we), .rd_active(rd_active)
   );

   fsb_burst #(.ADDR_W(ADDR_W)) u_burst (
      .clk(clk), .rst_n(rst_n), .bop(bop), .order_xor(order_xor),
      .addr_in(addr), .eff_addr(eff_addr), .nxt_addr(nxt_addr)
   );

   fsb_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
      .clk(clk), .lane_we(lane_we), .wr_addr(nxt_addr), .wr_data(dq_in),
      .rd_addr(eff_addr), .rd_data(rd_data)
   );

   assign dq_drv = rd_active & ~oe_n & ~doze;
   assign dq_out = dq_drv ? rd_data : '0;
endmodule

// File: rtl/fsb_sram_chk.sv
`timescale 1ns/1ps
module fsb_sram_chk #(
   parameter int unsigned ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_n,
   input logic              sel_a,
   input logic              sel_b_n,
   input logic              cpu_ld_n,
   input logic              cache_ld_n,
   input logic              adv_n,
   input logic              oe_n,
   input logic              doze,
   input logic              dq_drv,
   input logic [ADDR_W-1:0] eff_addr
);
   logic no_load;
   assign no_load = cache_ld_n & (cpu_ld_n | en_n);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !dq_drv);

   // R2
   cpu_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_ld_n && !en_n && sel_a && !sel_b_n && !doze) |=> (dq_drv || oe_n || doze));

   // R4
   burst_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (no_load && !adv_n && !doze) |=> $stable(eff_addr[ADDR_W-1:2]));

   // R6
   suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (no_load && adv_n && !doze) |=> $stable(eff_addr));

   // R12
   deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cache_ld_n && cpu_ld_n && en_n && !doze) |=> !dq_drv);

   // R13
   oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_drv);

   // R14
   doze_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      doze |-> !dq_drv);

   // R14
   doze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      doze |=> $stable(eff_addr));
endmodule

bind fsb_sram fsb_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_n(en_n), .sel_a(sel_a), .sel_b_n(sel_b_n),
   .cpu_ld_n(cpu_ld_n), .cache_ld_n(cache_ld_n), .adv_n(adv_n),
   .oe_n(oe_n), .doze(doze), .dq_drv(dq_drv), .eff_addr(eff_addr)
);

// File: tb/fsb_sram_tb.sv
`timescale 1ns/1ps
module fsb_sram_tb;
   logic        clk = 1'b0;
   logic        rst_n, en_n, sel_a, sel_b_n, cpu_ld_n, cache_ld_n, adv_n, order_xor;
   logic [5:0]  addr;
   logic        wr_all_n, wr_byte_n, oe_n, doze;
   logic [3:0]  lane_n;
   logic [35:0] dq_in, dw_out;
   logic [17:0] dn_out;
   logic        dw_drv, dn_drv;

   logic [35:0] mw [64];
   logic [17:0] mn [64];
   int checks = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   fsb_sram #(.ADDR_W(6), .LANES(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .en_n(en_n), .sel_a(sel_a), .sel_b_n(sel_b_n),
      .cpu_ld_n(cpu_ld_n), .cache_ld_n(cache_ld_n), .adv_n(adv_n), .order_xor(order_xor),
      .addr(addr), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
      .dq_in(dq_in), .oe_n(oe_n), .doze(doze), .dq_out(dw_out), .dq_drv(dw_drv));

   fsb_sram #(.ADDR_W(6), .LANES(2)) u_dut_narrow (
      .clk(clk), .rst_n(rst_n), .en_n(en_n), .sel_a(sel_a), .sel_b_n(sel_b_n),
      .cpu_ld_n(cpu_ld_n), .cache_ld_n(cache_ld_n), .adv_n(adv_n), .order_xor(order_xor),
      .addr(addr), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
      .dq_in(dq_in[17:0]), .oe_n(oe_n), .doze(doze), .dq_out(dn_out), .dq_drv(dn_drv));

   task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [35:0] pat(input int a, input int s);
      return {4'(s), 8'(a), 24'h5AC300 ^ 24'(a * 977 + s * 31)};
   endfunction

   function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                         input logic [3:0] m);
      logic [35:0] r = old;
      for (int i = 0; i < 4; i++)
         if (m[i]) r[i*9 +: 9] = nw[i*9 +: 9];
      return r;
   endfunction

   task automatic idle();
      en_n = 0; sel_a = 1; sel_b_n = 0; cpu_ld_n = 1; cache_ld_n = 1; adv_n = 1;
      wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF; oe_n = 0; doze = 0;
   endtask

   task automatic tick();
      @(posedge clk); #2;
   endtask

   task automatic gwrite(input int a, input logic [35:0] d);
      idle(); cache_ld_n = 0; addr = 6'(a); wr_all_n = 0; dq_in = d;
      tick();
      mw[a] = d; mn[a] = d[17:0];
      idle();
   endtask

   task automatic pread(input int a, input string req);
      idle(); cpu_ld_n = 0; addr = 6'(a);
      tick();
      chk(req, {35'd0, dw_drv}, 36'd1);
      chk(req, dw_out, mw[a]);
      chk(req, {18'd0, dn_out}, {18'd0, mn[a]});
      idle();
   endtask

   task automatic t_reset();
      idle(); rst_n = 0; addr = 0; dq_in = 0; order_xor = 0;
      repeat (3) tick();
      chk("R1 drive in reset", {35'd0, dw_drv}, 36'd0);
      rst_n = 1;
      tick();
      chk("R1 drive after reset", {35'd0, dw_drv}, 36'd0);
      chk("R1 data after reset", dw_out, 36'd0);
      chk("R1 narrow drive", {35'd0, dn_drv}, 36'd0);
   endtask

   task automatic t_fill();
      for (int a = 0; a < 32; a++) gwrite(a, pat(a, 1));
      pread(0, "R2 read 0");
      pread(17, "R2 read 17");
      idle(); cache_ld_n = 0; addr = 6'd31;
      tick();
      chk("R3 cache read", dw_out, mw[31]);
      chk("R3 cache read drv", {35'd0, dw_drv}, 36'd1);
      idle();
   endtask

   task automatic t_linear();
      order_xor = 0;
      pread(6, "R4 base");
      adv_n = 0;
      for (int i = 1; i <= 4; i++) begin
         tick();
         chk("R4 linear beat", dw_out, mw[{4'd1, 2'(2 + i)}]);
      end
      idle();
   endtask

   task automatic t_xor();
      order_xor = 1;
      pread(9, "R5 base");
      adv_n = 0;
      for (int i = 1; i <= 3; i++) begin
         tick();
         chk("R5 xor beat", dw_out, mw[{4'd2, 2'd1 ^ 2'(i)}]);
      end
      idle();
      order_xor = 0;
   endtask

   task automatic t_suspend();
      logic [35:0] x = pat(20, 7), y = pat(21, 8), z = pat(21, 9);
      pread(12, "R6 base");
      repeat (2) begin
         tick();
         chk("R6 hold", dw_out, mw[12]);
      end
      adv_n = 0;
      tick();
      chk("R6 step after hold", dw_out, mw[13]);
      idle(); cache_ld_n = 0; addr = 6'd20; wr_all_n = 0; dq_in = x;
      tick(); mw[20] = x; mn[20] = x[17:0];
      cache_ld_n = 1; adv_n = 0; dq_in = y;
      tick(); mw[21] = y; mn[21] = y[17:0];
      adv_n = 1; dq_in = z;
      tick(); mw[21] = z; mn[21] = z[17:0];
      idle();
      pread(20, "R6 burst write beat0");
      pread(21, "R6 burst write held beat");
   endtask

   task automatic t_lanes();
      logic [35:0] d = pat(3, 12), e = pat(4, 13);
      idle(); cache_ld_n = 0; addr = 6'd3; wr_byte_n = 0; lane_n = 4'b1010; dq_in = d;
      tick();
      mw[3] = merge(mw[3], d, 4'b0101);
      mn[3] = {mn[3][17:9], d[8:0]};
      idle();
      pread(3, "R8 lane write");
      idle(); cache_ld_n = 0; addr = 6'd3; dq_in = ~d;
      tick();
      chk("R8 no-write read drv", {35'd0, dw_drv}, 36'd1);
      chk("R8 no-write read", dw_out, mw[3]);
      idle(); cache_ld_n = 0; addr = 6'd4; wr_all_n = 0; wr_byte_n = 0; lane_n = 4'b1110; dq_in = e;
      tick();
      mw[4] = e; mn[4] = e[17:0];
      idle();
      pread(4, "R7 global write");
   endtask

   task automatic t_narrow();
      logic [35:0] f = pat(5, 14);
      idle(); cache_ld_n = 0; addr = 6'd5; wr_byte_n = 0; lane_n = 4'b0011; dq_in = f;
      tick();
      mw[5] = merge(mw[5], f, 4'b1100);
      chk("R9 narrow read drv", {35'd0, dn_drv}, 36'd1);
      chk("R9 narrow read data", {18'd0, dn_out}, {18'd0, mn[5]});
      idle();
      pread(5, "R9 upper selects ignored");
   endtask

   task automatic t_cpu_ignored();
      pread(2, "R10 base");
      cpu_ld_n = 0; en_n = 1; addr = 6'd7;
      tick();
      chk("R10 drv kept", {35'd0, dw_drv}, 36'd1);
      chk("R10 data kept", dw_out, mw[2]);
      idle();
   endtask

   task automatic t_both();
      idle(); cpu_ld_n = 0; cache_ld_n = 0; wr_all_n = 0; addr = 6'd4; dq_in = pat(4, 15);
      tick();
      chk("R11 read wins drv", {35'd0, dw_drv}, 36'd1);
      chk("R11 read wins data", dw_out, mw[4]);
      idle();
      pread(4, "R11 array unchanged");
   endtask

   task automatic t_desel();
      pread(1, "R12 base");
      cache_ld_n = 0; en_n = 1; addr = 6'd1;
      tick();
      chk("R12 disabled drv", {35'd0, dw_drv}, 36'd0);
      idle(); wr_all_n = 0; adv_n = 0; dq_in = pat(1, 3);
      tick();
      chk("R12 idle drv", {35'd0, dw_drv}, 36'd0);
      idle();
      pread(1, "R12 no write at 1");
      pread(2, "R12 no write at 2");
      idle(); cache_ld_n = 0; sel_a = 0; addr = 6'd9;
      tick();
      chk("R12 sel_a low", {35'd0, dw_drv}, 36'd0);
      idle(); cpu_ld_n = 0; sel_b_n = 1; addr = 6'd9;
      tick();
      chk("R12 sel_b_n high", {35'd0, dw_drv}, 36'd0);
      idle();
   endtask

   task automatic t_oe();
      pread(8, "R13 base");
      oe_n = 1; #1;
      chk("R13 oe off drv", {35'd0, dw_drv}, 36'd0);
      chk("R13 oe off data", dw_out, 36'd0);
      tick();
      chk("R13 oe off after edge", {35'd0, dw_drv}, 36'd0);
      oe_n = 0; #1;
      chk("R13 oe back drv", {35'd0, dw_drv}, 36'd1);
      chk("R13 oe back data", dw_out, mw[8]);
   endtask

   task automatic t_doze();
      pread(10, "R14 base");
      doze = 1; #1;
      chk("R14 doze drv", {35'd0, dw_drv}, 36'd0);
      adv_n = 0; wr_all_n = 0; dq_in = pat(11, 5);
      repeat (2) tick();
      doze = 0; adv_n = 1; wr_all_n = 1; #1;
      chk("R14 wake drv", {35'd0, dw_drv}, 36'd1);
      chk("R14 wake same word", dw_out, mw[10]);
      pread(11, "R14 no write in doze");
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_fill();
      t_linear();
      t_xor();
      t_suspend();
      t_lanes();
      t_narrow();
      t_cpu_ignored();
      t_both();
      t_desel();
      t_oe();
      t_doze();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule